// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a small array of one-time-programmable security words, together with the lock words that guard them. It sits behind a flash-style write port. A write whose low data byte is a program opcode arms the block. The next write supplies the 16-bit data to the same word address. Stored bits can only be cleared, never set, because each program ANDs the new data into the old contents. Every word of the array belongs to a protection region. Each region has a lock bit, and once that bit is cleared the region refuses all further programming for good.

The array is split into two parts. The first part is a 128-bit register of eight words. Its lower four words hold a factory identifier, locked from reset. Its upper four words are free for the user. Above it sit sixteen more 128-bit registers. Two lock words bracket the first register. The lower lock word guards the two halves of the first register. The upper lock word has one bit per upper register. Errors are reported in a status byte and stay set until software clears them. A synchronous read port returns any word or lock word.

After reset the block sweeps the array once, one word per cycle, to load the factory identifier and set all other words to ones. It reports not-ready until the sweep is done.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset release, status bit 7 (ready) stays 0 for 136 clock edges and reads 1 after the 136th. The reset contents are then: the lock word at 0x080 reads 0xFFFE, the lock word at 0x089 reads 0xFFFF, factory word k (k = 0..3) at address 0x081+k reads bits [16k+15:16k] of the FACTORY_ID parameter, and every other protection word reads 0xFFFF.
- R2: A write with low data byte 0xC0 while ready arms a word program and drops ready on the next cycle. The next write to the same address stores old AND data into that word, and ready returns after that write.
- R3: No stored word or lock bit ever goes from 0 back to 1. A second program to the same word yields the AND of both data values, and writing 0xFFFF to a lock word leaves it unchanged.
- R4: A word program armed at an address outside the word space sets status bit 4 (program error) and changes nothing. The word space is 0x081..0x088 and 0x08A..0x109, so a lock address counts as outside it.
- R5: If the data write goes to a different address from the armed address, status bit 4 is set and neither address changes.
- R6: A word program into a locked region sets both status bit 4 and status bit 1 (lock error) and leaves the word unchanged. The factory half (0x081..0x084) is locked from reset by bit 0 of the lower lock word.
- R7: Clearing bit 1 of the lower lock word (for example by writing 0xFFFD) locks the user half 0x085..0x088.
- R8: Clearing bit n of the upper lock word locks upper register n, at addresses 0x08A+8n .. 0x08A+8n+7, and no other register.
- R9: A write with low data byte 0xC8 arms a lock program. The data write must go to 0x080 or 0x089 and at the same address, otherwise status bit 4 is set and neither lock word changes.
- R10: The error bits are sticky. Only a write with low data byte 0x50 while ready clears them. Other opcodes while ready are ignored. Status bits 6, 5, 3, 2 and 0 read 0.
- R11: rd_data shows the word or lock word addressed by rd_addr at the previous clock edge. Unmapped addresses read 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for opcode or data cycles |
| wr_addr | input | 9 | Word address of the write |
| wr_data | input | 16 | Opcode (low byte) or program data |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 16 | Read data, one cycle after rd_addr |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
Every write takes effect at the clock edge that samples it. Status bits and stored contents change at that edge. A read presented at one edge returns its data after the next edge. The bench drives writes on the falling edge and updates its reference model just after the rising edge that takes them. It compares the whole status byte with the model on every falling edge. Each read is compared one full cycle after its address is driven. The reset sweep is checked by counting exactly 135 edges with ready low and then one more edge with ready high.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OP_PROG_WORD = 8'hC0;
  localparam logic [7:0] OP_PROG_LOCK = 8'hC8;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;

  localparam int ST_READY    = 7;
  localparam int ST_PROG_ERR = 4;
  localparam int ST_LOCK_ERR = 1;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_WAIT} ctl_state_t;
  typedef enum logic [1:0] {K_NONE, K_WORD, K_LOCK0, K_LOCK1} addr_kind_t;
endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map import otp_pkg::*; #(
  parameter int ADDR_W        = 9,
  parameter int WORDS_PER_REG = 8,
  parameter int NUM_UPPER     = 16,
  parameter int LOCK0_ADDR    = 'h80,
  parameter int IDX_W         = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_kind_t        kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int R0_BASE    = LOCK0_ADDR + 1;
  localparam int LOCK1_ADDR = LOCK0_ADDR + WORDS_PER_REG + 1;
  localparam int UP_BASE    = LOCK1_ADDR + 1;
  localparam int UP_END     = UP_BASE + NUM_UPPER * WORDS_PER_REG;

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (int'(addr) == LOCK0_ADDR) begin
      kind = K_LOCK0;
    end else if (int'(addr) == LOCK1_ADDR) begin
      kind = K_LOCK1;
    end else if (int'(addr) >= R0_BASE && int'(addr) < R0_BASE + WORDS_PER_REG) begin
      kind = K_WORD;
      idx  = IDX_W'(int'(addr) - R0_BASE);
    end else if (int'(addr) >= UP_BASE && int'(addr) < UP_END) begin
      kind = K_WORD;
      idx  = IDX_W'(WORDS_PER_REG + int'(addr) - UP_BASE);
    end
  end
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 136,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[w_addr] <= w_data;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/otp_lock_regs.sv
module otp_lock_regs #(
  parameter int DW            = 16,
  parameter int NUM_UPPER     = 16,
  parameter int WORDS_PER_REG = 8,
  parameter int IDX_W         = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we0,
  input  logic                 we1,
  input  logic [DW-1:0]        wdata,
  input  logic [IDX_W-1:0]     chk_idx,
  output logic                 locked,
  output logic [DW-1:0]        lock0_q,
  output logic [NUM_UPPER-1:0] lock1_q
);
  localparam int HALF = WORDS_PER_REG / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock0_q <= {{(DW-1){1'b1}}, 1'b0};
      lock1_q <= '1;
    end else begin
      if (we0) lock0_q <= lock0_q & wdata;
      if (we1) lock1_q <= lock1_q & wdata[NUM_UPPER-1:0];
    end
  end

  always_comb begin
    int reg_n;
    int off;
    reg_n  = int'(chk_idx) / WORDS_PER_REG;
    off    = int'(chk_idx) % WORDS_PER_REG;
    locked = 1'b0;
    if (reg_n == 0) begin
      locked = (off >= HALF) ? !lock0_q[1] : !lock0_q[0];
    end
    for (int n = 0; n < NUM_UPPER; n++) begin
      if (reg_n == n + 1) locked = !lock1_q[n];
    end
  end
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl import otp_pkg::*; #(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_REG = 8,
  parameter int NUM_UPPER     = 16,
  parameter int LOCK0_ADDR    = 'h80,
  parameter logic [DATA_W*WORDS_PER_REG/2-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status
);
  localparam int NUM_WORDS = (NUM_UPPER + 1) * WORDS_PER_REG;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int HALF      = WORDS_PER_REG / 2;

  ctl_state_t        st_q;
  logic [IDX_W-1:0]  init_cnt;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic              cmd_lock_q;
  logic              ready_q, prog_err_q, lock_err_q;

  addr_kind_t        wkind, ckind, rkind;
  logic [IDX_W-1:0]  widx, cidx, ridx;
  logic [7:0]        op;

  logic              init_act, data_cyc, same_addr, cur_locked;
  logic              set_perr, set_lerr, word_we, lk_we0, lk_we1;
  logic              m_we, ra_en;
  logic [IDX_W-1:0]  m_waddr;
  logic [DATA_W-1:0] m_wdata, init_word, old_q, rb_q;
  logic [DATA_W-1:0] lock0_val;
  logic [NUM_UPPER-1:0] lock1_val;
  logic              rd_word_q;
  logic [DATA_W-1:0] rd_aux_q;

  assign op = wr_data[7:0];

  otp_addr_map #(.ADDR_W(ADDR_W), .WORDS_PER_REG(WORDS_PER_REG), .NUM_UPPER(NUM_UPPER),
                 .LOCK0_ADDR(LOCK0_ADDR), .IDX_W(IDX_W))
    u_wmap (.addr(wr_addr), .kind(wkind), .idx(widx));
  otp_addr_map #(.ADDR_W(ADDR_W), .WORDS_PER_REG(WORDS_PER_REG), .NUM_UPPER(NUM_UPPER),
                 .LOCK0_ADDR(LOCK0_ADDR), .IDX_W(IDX_W))
    u_cmap (.addr(cmd_addr_q), .kind(ckind), .idx(cidx));
  otp_addr_map #(.ADDR_W(ADDR_W), .WORDS_PER_REG(WORDS_PER_REG), .NUM_UPPER(NUM_UPPER),
                 .LOCK0_ADDR(LOCK0_ADDR), .IDX_W(IDX_W))
    u_rmap (.addr(rd_addr), .kind(rkind), .idx(ridx));

  otp_lock_regs #(.DW(DATA_W), .NUM_UPPER(NUM_UPPER), .WORDS_PER_REG(WORDS_PER_REG), .IDX_W(IDX_W))
    u_locks (.clk(clk), .rst(rst), .we0(lk_we0), .we1(lk_we1), .wdata(wr_data),
             .chk_idx(cidx), .locked(cur_locked), .lock0_q(lock0_val), .lock1_q(lock1_val));

  otp_word_mem #(.DW(DATA_W), .DEPTH(NUM_WORDS), .AW(IDX_W))
    u_mem (.clk(clk), .we(m_we), .w_addr(m_waddr), .w_data(m_wdata),
           .a_en(ra_en), .a_addr(widx), .a_q(old_q), .b_addr(ridx), .b_q(rb_q));

  assign init_act  = (st_q == S_INIT);
  assign data_cyc  = (st_q == S_WAIT) && wr_en;
  assign same_addr = (wr_addr == cmd_addr_q);
  assign ra_en     = (st_q == S_IDLE) && wr_en && (wkind == K_WORD);

  always_comb begin
    init_word = '1;
    for (int k = 0; k < HALF; k++) begin
      if (int'(init_cnt) == k) init_word = FACTORY_ID[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    set_perr = 1'b0;
    set_lerr = 1'b0;
    word_we  = 1'b0;
    lk_we0   = 1'b0;
    lk_we1   = 1'b0;
    if (data_cyc) begin
      if (cmd_lock_q) begin
        if (!same_addr)            set_perr = 1'b1;
        else if (ckind == K_LOCK0) lk_we0   = 1'b1;
        else if (ckind == K_LOCK1) lk_we1   = 1'b1;
        else                       set_perr = 1'b1;
      end else begin
        if (!same_addr || ckind != K_WORD) begin
          set_perr = 1'b1;
        end else if (cur_locked) begin
          set_perr = 1'b1;
          set_lerr = 1'b1;
        end else begin
          word_we = 1'b1;
        end
      end
    end
  end

  assign m_we    = init_act || word_we;
  assign m_waddr = init_act ? init_cnt : cidx;
  assign m_wdata = init_act ? init_word : (old_q & wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_INIT;
      init_cnt   <= '0;
      cmd_addr_q <= '0;
      cmd_lock_q <= 1'b0;
      ready_q    <= 1'b0;
      prog_err_q <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      case (st_q)
        S_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == IDX_W'(NUM_WORDS - 1)) begin
            st_q    <= S_IDLE;
            ready_q <= 1'b1;
          end
        end
        S_IDLE: begin
          if (wr_en) begin
            if (op == OP_PROG_WORD || op == OP_PROG_LOCK) begin
              cmd_addr_q <= wr_addr;
              cmd_lock_q <= (op == OP_PROG_LOCK);
              st_q       <= S_WAIT;
              ready_q    <= 1'b0;
            end else if (op == OP_CLR_STAT) begin
              prog_err_q <= 1'b0;
              lock_err_q <= 1'b0;
            end
          end
        end
        S_WAIT: begin
          if (wr_en) begin
            st_q       <= S_IDLE;
            ready_q    <= 1'b1;
            prog_err_q <= prog_err_q | set_perr;
            lock_err_q <= lock_err_q | set_lerr;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word_q <= 1'b0;
      rd_aux_q  <= '0;
    end else begin
      rd_word_q <= (rkind == K_WORD);
      case (rkind)
        K_LOCK0: rd_aux_q <= lock0_val;
        K_LOCK1: rd_aux_q <= DATA_W'(lock1_val);
        default: rd_aux_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_word_q ? rb_q : rd_aux_q;

  always_comb begin
    status              = '0;
    status[ST_READY]    = ready_q;
    status[ST_PROG_ERR] = prog_err_q;
    status[ST_LOCK_ERR] = lock_err_q;
  end
endmodule

// File: rtl/otp_prot_ctrl_chk.sv
module otp_prot_ctrl_chk import otp_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int NUM_UPPER = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [7:0]           wr_op,
  input logic [7:0]           status,
  input logic [DATA_W-1:0]    lock0_q,
  input logic [NUM_UPPER-1:0] lock1_q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3: lock bits never return to 1
  assert_lock0_no_rise_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (lock0_q & ~$past(lock0_q)) == '0);
  assert_lock1_no_rise_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (lock1_q & ~$past(lock1_q)) == '0);

  // R6: factory half stays locked
  assert_factory_locked_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !lock0_q[0]);

  // R6: a lock error always comes with a program error
  assert_lock_err_has_prog_R6: assert property (@(posedge clk) disable iff (rst)
    status[ST_LOCK_ERR] |-> status[ST_PROG_ERR]);

  // R10: error bit survives unless a clear is accepted
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (status[ST_PROG_ERR] && !(wr_en && status[ST_READY] && wr_op == OP_CLR_STAT))
      |=> status[ST_PROG_ERR]);

  // R2: an accepted program opcode drops ready
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (status[ST_READY] && wr_en && (wr_op == OP_PROG_WORD || wr_op == OP_PROG_LOCK))
      |=> !status[ST_READY]);
endmodule

bind otp_prot_ctrl otp_prot_ctrl_chk #(.DATA_W(DATA_W), .NUM_UPPER(NUM_UPPER)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_data[7:0]), .status(status),
  .lock0_q(lock0_val), .lock1_q(lock1_val));

// File: tb/sim_otp_prot_ctrl.sv
`timescale 1ns/1ps
module sim_otp_prot_ctrl;
  localparam int NW = 136;
  localparam logic [63:0] UID = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  status;

  int n_chk = 0;
  int n_err = 0;
  bit mon_on = 0;

  logic [15:0] m_mem [NW];
  logic [15:0] m_lock0, m_lock1;
  bit          m_wait, m_klock, m_perr, m_lerr;
  logic [8:0]  m_caddr;

  otp_prot_ctrl u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                    .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_idx(input int a);
    if (a >= 'h81 && a <= 'h88) return a - 'h81;
    if (a >= 'h8A && a <= 'h109) return 8 + a - 'h8A;
    return -1;
  endfunction

  function automatic bit m_locked(input int i);
    if (i < 4) return !m_lock0[0];
    if (i < 8) return !m_lock0[1];
    return !m_lock1[(i - 8) / 8];
  endfunction

  function automatic logic [15:0] m_read(input int a);
    int i;
    if (a == 'h80) return m_lock0;
    if (a == 'h89) return m_lock1;
    i = m_idx(a);
    if (i >= 0) return m_mem[i];
    return 16'h0000;
  endfunction

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = '0;
    s[7] = !m_wait;
    s[4] = m_perr;
    s[1] = m_lerr;
    return s;
  endfunction

  task automatic model_write(input logic [8:0] a, input logic [15:0] d);
    int i;
    if (m_wait) begin
      m_wait = 0;
      if (m_klock) begin
        if (a != m_caddr || (a != 9'h080 && a != 9'h089)) m_perr = 1;
        else if (a == 9'h080) m_lock0 = m_lock0 & d;
        else m_lock1 = m_lock1 & d;
      end else begin
        i = m_idx(int'(m_caddr));
        if (a != m_caddr || i < 0) m_perr = 1;
        else if (m_locked(i)) begin m_perr = 1; m_lerr = 1; end
        else m_mem[i] = m_mem[i] & d;
      end
    end else begin
      case (d[7:0])
        8'hC0: begin m_wait = 1; m_klock = 0; m_caddr = a; end
        8'hC8: begin m_wait = 1; m_klock = 1; m_caddr = a; end
        8'h50: begin m_perr = 0; m_lerr = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic prog(input logic [8:0] a, input logic [15:0] d);
    wr(a, 16'h00C0);
    wr(a, d);
  endtask

  task automatic prog_lock(input logic [8:0] a, input logic [15:0] d);
    wr(a, 16'h00C8);
    wr(a, d);
  endtask

  task automatic rd(input string tag, input logic [8:0] a);
    logic [15:0] exp;
    @(negedge clk);
    rd_addr = a;
    exp = m_read(int'(a));
    @(posedge clk);
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  // R10: status byte compared with the model on every falling edge
  always @(negedge clk) begin
    if (mon_on) chk("R10 status", {8'h00, status}, {8'h00, m_status()});
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NW; i++) m_mem[i] = (i < 4) ? UID[i*16 +: 16] : 16'hFFFF;
    m_lock0 = 16'hFFFE; m_lock1 = 16'hFFFF;
    m_wait = 0; m_klock = 0; m_perr = 0; m_lerr = 0; m_caddr = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready low at release", {8'h00, status}, 16'h0000);
    repeat (135) @(posedge clk);
    @(negedge clk);
    chk("R1 ready low after 135 edges", {15'h0, status[7]}, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready after sweep", {8'h00, status}, 16'h0080);
    mon_on = 1;

    rd("R1 lock0 reset", 9'h080);
    rd("R1 lock1 reset", 9'h089);
    for (int k = 0; k < 4; k++) rd("R1 factory word", 9'(9'h081 + k));
    rd("R1 user word", 9'h085);
    rd("R1 upper word", 9'h0F0);

    // R2 basic program
    prog(9'h085, 16'h1234);
    rd("R2 programmed word", 9'h085);
    // R3 AND accumulate
    prog(9'h085, 16'hFF00);
    rd("R3 and of two programs", 9'h085);
    prog(9'h085, 16'hFFFF);
    rd("R3 ones do not restore", 9'h085);

    // R6 factory half locked
    prog(9'h081, 16'h0000);
    rd("R6 factory word unchanged", 9'h081);
    wr(9'h000, 16'h0050);

    // R4 outside word space
    prog(9'h120, 16'h0000);
    wr(9'h000, 16'h0050);
    prog(9'h089, 16'h0000);
    rd("R4 lock1 untouched by word program", 9'h089);
    wr(9'h000, 16'h0050);

    // R5 address mismatch
    wr(9'h086, 16'h00C0);
    wr(9'h087, 16'h0000);
    rd("R5 armed word unchanged", 9'h086);
    rd("R5 other word unchanged", 9'h087);

    // R10 sticky across a good program, then unknown opcode ignored, then clear
    prog(9'h087, 16'hABCD);
    rd("R10 program works with sticky error", 9'h087);
    wr(9'h000, 16'h0077);
    wr(9'h000, 16'h0050);

    // R9 lock program at a non-lock address
    prog_lock(9'h085, 16'h0000);
    rd("R9 lock0 unchanged", 9'h080);
    rd("R9 word unchanged", 9'h085);
    wr(9'h080, 16'h00C8);
    wr(9'h089, 16'h0000);
    rd("R9 lock1 unchanged on mismatch", 9'h089);
    wr(9'h000, 16'h0050);

    // R7 user half lock
    prog_lock(9'h080, 16'hFFFD);
    rd("R7 lock0 value", 9'h080);
    prog(9'h088, 16'h0000);
    rd("R7 user word locked", 9'h088);
    wr(9'h000, 16'h0050);
    prog_lock(9'h080, 16'hFFFF);
    rd("R3 lock0 cannot rise", 9'h080);

    // R8 upper register 2
    prog(9'h09A, 16'h5A5A);
    prog_lock(9'h089, 16'hFFFB);
    rd("R8 lock1 value", 9'h089);
    prog(9'h09A, 16'h0000);
    rd("R8 reg2 locked", 9'h09A);
    prog(9'h0A1, 16'h0000);
    rd("R8 reg2 last word locked", 9'h0A1);
    wr(9'h000, 16'h0050);
    prog(9'h099, 16'h0F0F);
    rd("R8 reg1 still open", 9'h099);
    prog(9'h0A2, 16'h3C3C);
    rd("R8 reg3 still open", 9'h0A2);
    prog(9'h109, 16'h00FF);
    rd("R8 last upper word", 9'h109);

    // R11 unmapped reads
    rd("R11 above space", 9'h10A);
    rd("R11 below space", 9'h07F);

    // mixed pattern
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      logic [8:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = 9'(9'h081 + (int'(lfsr) % 137));
      prog(a, lfsr ^ 16'h3F3F);
      rd("R2 mixed readback", a);
    end
    wr(9'h000, 16'h0050);
    rd("R11 final lock1", 9'h089);

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule